// File: doc/BRIEF.md
# Cascadable Serial Codec Port Node

This block is the digital serial-port controller of one converter channel. Several identical nodes can be chained: each node's serial output (data plus frame sync) feeds the next node's serial input, and the last node feeds the host. On every sample event a node sends the ADC word presented on its parallel input. It also passes on, or consumes, every word it receives from upstream.

The node starts in program mode. Here, control words carry a hop address. A node that sees address zero consumes the word and writes one of its three configuration registers. A node that sees a nonzero address decrements it and passes the word downstream. Writing the mode bit of register A moves the node into data mode. In data mode every received word is a DAC word. The node counts incoming frames and latches the word that completes a full cascade into its DAC output. The configuration fields drive the rest of the channel (clock divider, serial-clock rate, sample rate, power enables) and appear as plain outputs.

Top module: `cascade_codec_port`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the node clears itself. `ser_out`, `ser_out_fs`, `dac_load` and `data_mode` become 0, `dac_word` becomes 0, every configuration field becomes 0, and the frame counter becomes 0.
- R2: Both serial directions use the same frame. `fs` is high for exactly one clock. Then 16 data bits follow in the next 16 clocks, most significant bit first.
- R3: A one-clock `sample_evt` pulse while the transmitter is idle makes `ser_out_fs` high in the next cycle. The `adc_word` value present with the pulse is then shifted out.
- R4: In program mode, a received word with bit 15 = 1 and address bits 14:12 = 0 is consumed and not sent onward. Its bits 7:0 are written to the register chosen by bits 11:9: 0 selects A, 1 selects B, 2 selects C. Select values 3 to 7 change nothing.
- R5: In program mode, a received word with bit 15 = 1 and a nonzero address is sent onward with bits 14:12 reduced by one. All other bits are unchanged.
- R6: In program mode, a received word with bit 15 = 0 is sent onward unchanged.
- R7: Register layout. In register A, bit 0 is the mode (1 = data) and bits 3:1 are the cascade length. In register B, bits 2:0 are `mclk_div`, bits 4:3 are `sclk_rate` and bits 7:5 are `fs_rate`. Register C drives `pwr_en`. Any write to register A zeroes the frame counter.
- R8: In data mode, every received word increments the frame counter. If the new count equals the cascade length (a length of 0 counts as 1), the word is loaded into `dac_word`, `dac_load` pulses for one cycle, the counter returns to 0 and nothing is sent. Otherwise the word is sent onward unchanged.
- R9: In data mode, no word is decoded as a control word, whatever bit 15 holds. Only reset returns the node to program mode.
- R10: A transmit request that arrives while a word is being shifted out is dropped. When a sample event and a forward fall in the same cycle, the sample event wins and the forward is dropped.
- R11: `dac_word` changes only together with a `dac_load` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data from upstream |
| ser_in_fs | input | 1 | Frame sync from upstream |
| ser_out | output | 1 | Serial data to downstream |
| ser_out_fs | output | 1 | Frame sync to downstream |
| sample_evt | input | 1 | One-cycle sample-event strobe |
| adc_word | input | 16 | Parallel ADC word sent on a sample event |
| dac_word | output | 16 | Latched DAC word |
| dac_load | output | 1 | One-cycle pulse when `dac_word` is updated |
| data_mode | output | 1 | 1 once the node is in data mode |
| chain_len | output | 3 | Cascade-length field of register A |
| mclk_div | output | 3 | Master-clock divider field of register B |
| sclk_rate | output | 2 | Serial-clock rate field of register B |
| fs_rate | output | 3 | Sample-rate field of register B |
| pwr_en | output | 8 | Power-up enables from register C |

## Verification
The assertions check on every cycle that the output frame sync and the DAC strobe are single-cycle pulses, and that a DAC strobe only occurs in data mode. They also check that data mode never falls back, that the configuration outputs move only after a received word, and that `dac_word` never changes without its strobe. Only the bench's scenarios can show the content of what is routed: address decrement, consumption of zero-address words, and the exact bit order on the wire. The same holds for the frame-count threshold and its zero-length case, and for the dropping of requests while busy or in a collision.

// File: rtl/cnode_pkg.sv
// Shared constants and the control-word layout for the cascadable codec port.
// Assumes a 16-bit serial word; all field widths derive from the constants below.
package cnode_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 3;
    localparam int DATA_W = 8;
    localparam int PAD_W  = WORD_W - 1 - ADDR_W - SEL_W - DATA_W;
    localparam int CNT_W  = 3;
    localparam int NREG   = 3;

    // Register indices addressed by the select field
    localparam int REG_A = 0;
    localparam int REG_B = 1;
    localparam int REG_C = 2;

    // Field positions inside the registers
    localparam int MODE_BIT = 0;
    localparam int LEN_LSB  = 1;
    localparam int DIV_W    = 3;
    localparam int SCK_W    = 2;
    localparam int RATE_W   = 3;

    typedef struct packed {
        logic              ctl;
        logic [ADDR_W-1:0] addr;
        logic [SEL_W-1:0]  sel;
        logic [PAD_W-1:0]  pad;
        logic [DATA_W-1:0] data;
    } ctl_word_t;
endpackage

// File: rtl/cnode_rx.sv
// Serial receiver: waits for a one-clock frame sync, then shifts in W bits
// MSB first. It pulses done for one cycle with the assembled word.
// Assumes frame syncs that arrive during a word are not meaningful and ignores them.
module cnode_rx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sin,
    input  logic         sin_fs,
    output logic         done,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] left;

    // Shift in the frame bits and publish the completed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            left <= '0;
            done <= 1'b0;
            word <= '0;
        end else begin
            done <= 1'b0;
            if (left != '0) begin
                sh   <= {sh[W-2:0], sin};
                left <= left - CW'(1);
                if (left == CW'(1)) begin
                    done <= 1'b1;
                    word <= {sh[W-2:0], sin};
                end
            end else if (sin_fs) begin
                left <= CW'(W);
            end
        end
    end
endmodule

// File: rtl/cnode_tx.sv
// Serial transmitter: on start it drives a one-clock frame sync, then W bits
// MSB first. Ready is high only when no word is in flight; a start while busy
// is ignored. Assumes the caller gates start with ready.
module cnode_tx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] din,
    output logic         ready,
    output logic         sout,
    output logic         sout_fs
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] left;

    assign ready = (left == '0);

    // Emit the frame sync, then shift the word out bit by bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            left    <= '0;
            sout    <= 1'b0;
            sout_fs <= 1'b0;
        end else if (start && ready) begin
            sh      <= din;
            left    <= CW'(W);
            sout    <= 1'b0;
            sout_fs <= 1'b1;
        end else if (!ready) begin
            sout    <= sh[W-1];
            sh      <= {sh[W-2:0], 1'b0};
            left    <= left - CW'(1);
            sout_fs <= 1'b0;
        end else begin
            sout    <= 1'b0;
            sout_fs <= 1'b0;
        end
    end
endmodule

// File: rtl/cnode_cfg.sv
// Configuration bank: NREG registers of DW bits, one picked by wr_sel on
// each write. Select values beyond the bank are ignored. The registers are
// returned flattened, register 0 in the low bits.
module cnode_cfg #(
    parameter int NREG = 3,
    parameter int DW   = 8,
    parameter int SW   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SW-1:0]      wr_sel,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] bank
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r;

        // Hold one configuration register, written when its index is selected
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= '0;
            else if (wr_en && (wr_sel == SW'(g)))
                r <= wr_data;
        end

        assign bank[g*DW +: DW] = r;
    end
endmodule

// File: rtl/cnode_route.sv
// Routing and data-mode logic. Program mode: it decodes received control
// words and either writes a register or forwards the word (decrementing a
// nonzero address). Data mode: it counts received frames and latches the one
// that completes the cascade into the DAC output. It also arbitrates the
// transmitter between sample events and forwards.
// Assumes rx_done is a single-cycle pulse.
module cnode_route
    import cnode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              sample_evt,
    input  logic [WORD_W-1:0] adc_word,
    input  logic              tx_ready,
    input  logic              data_mode,
    input  logic [CNT_W-1:0]  chain_len,
    output logic              tx_start,
    output logic [WORD_W-1:0] tx_word,
    output logic              cfg_we,
    output logic [SEL_W-1:0]  cfg_sel,
    output logic [DATA_W-1:0] cfg_data,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_load
);
    ctl_word_t        cw;
    ctl_word_t        fw;
    logic             fwd_req;
    logic             dac_hit;
    logic [CNT_W-1:0] frm_cnt;
    logic [CNT_W:0]   cnt_nxt;
    logic [CNT_W:0]   thr;

    assign cw       = ctl_word_t'(rx_word);
    assign cfg_sel  = cw.sel;
    assign cfg_data = cw.data;
    assign cnt_nxt  = {1'b0, frm_cnt} + (CNT_W+1)'(1);
    assign thr      = (chain_len == '0) ? (CNT_W+1)'(1) : {1'b0, chain_len};

    // Decide what a completed received word does in the current mode
    always_comb begin
        cfg_we  = 1'b0;
        fwd_req = 1'b0;
        dac_hit = 1'b0;
        fw      = cw;
        if (rx_done) begin
            if (!data_mode) begin
                if (cw.ctl && (cw.addr == '0)) begin
                    cfg_we = 1'b1;
                end else begin
                    fwd_req = 1'b1;
                    if (cw.ctl)
                        fw.addr = cw.addr - ADDR_W'(1);
                end
            end else if (cnt_nxt == thr) begin
                dac_hit = 1'b1;
            end else begin
                fwd_req = 1'b1;
            end
        end
    end

    // Give the transmitter to the sample event first, otherwise to a forward
    always_comb begin
        tx_start = tx_ready && (sample_evt || fwd_req);
        tx_word  = sample_evt ? adc_word : WORD_W'(fw);
    end

    // Count data-mode frames; a write to register A restarts the count
    always_ff @(posedge clk) begin
        if (!rst_n)
            frm_cnt <= '0;
        else if (cfg_we && (cw.sel == SEL_W'(REG_A)))
            frm_cnt <= '0;
        else if (rx_done && data_mode)
            frm_cnt <= dac_hit ? '0 : cnt_nxt[CNT_W-1:0];
    end

    // Latch the DAC word and pulse its strobe when the cascade is complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_word <= '0;
            dac_load <= 1'b0;
        end else begin
            dac_load <= dac_hit;
            if (dac_hit)
                dac_word <= rx_word;
        end
    end
endmodule

// File: rtl/cascade_codec_port.sv
// Top of one cascadable codec serial-port node: receiver, router, config
// bank and transmitter. The serial bit clock is clk itself. Register fields
// are exported as plain outputs.
module cascade_codec_port
    import cnode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              ser_in_fs,
    output logic              ser_out,
    output logic              ser_out_fs,
    input  logic              sample_evt,
    input  logic [WORD_W-1:0] adc_word,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_load,
    output logic              data_mode,
    output logic [CNT_W-1:0]  chain_len,
    output logic [DIV_W-1:0]  mclk_div,
    output logic [SCK_W-1:0]  sclk_rate,
    output logic [RATE_W-1:0] fs_rate,
    output logic [DATA_W-1:0] pwr_en
);
    logic                   rx_done;
    logic [WORD_W-1:0]      rx_word;
    logic                   tx_start;
    logic                   tx_ready;
    logic [WORD_W-1:0]      tx_word;
    logic                   cfg_we;
    logic [SEL_W-1:0]       cfg_sel;
    logic [DATA_W-1:0]      cfg_data;
    logic [NREG*DATA_W-1:0] bank;
    logic [DATA_W-1:0]      reg_a;
    logic [DATA_W-1:0]      reg_b;
    logic [DATA_W-1:0]      reg_c;

    assign reg_a     = bank[REG_A*DATA_W +: DATA_W];
    assign reg_b     = bank[REG_B*DATA_W +: DATA_W];
    assign reg_c     = bank[REG_C*DATA_W +: DATA_W];
    assign data_mode = reg_a[MODE_BIT];
    assign chain_len = reg_a[LEN_LSB +: CNT_W];
    assign mclk_div  = reg_b[0 +: DIV_W];
    assign sclk_rate = reg_b[DIV_W +: SCK_W];
    assign fs_rate   = reg_b[DIV_W+SCK_W +: RATE_W];
    assign pwr_en    = reg_c;

    cnode_rx #(.W(WORD_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sin    (ser_in),
        .sin_fs (ser_in_fs),
        .done   (rx_done),
        .word   (rx_word)
    );

    cnode_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_done    (rx_done),
        .rx_word    (rx_word),
        .sample_evt (sample_evt),
        .adc_word   (adc_word),
        .tx_ready   (tx_ready),
        .data_mode  (data_mode),
        .chain_len  (chain_len),
        .tx_start   (tx_start),
        .tx_word    (tx_word),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .dac_word   (dac_word),
        .dac_load   (dac_load)
    );

    cnode_cfg #(.NREG(NREG), .DW(DATA_W), .SW(SEL_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_data),
        .bank    (bank)
    );

    cnode_tx #(.W(WORD_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .din     (tx_word),
        .ready   (tx_ready),
        .sout    (ser_out),
        .sout_fs (ser_out_fs)
    );
endmodule

// File: rtl/cascade_codec_port_chk.sv
// Checker for cascade_codec_port, attached by bind. It watches the
// output pulses, the mode bit, the configuration fields and the DAC word.
module cascade_codec_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ser_out_fs,
    input logic        dac_load,
    input logic [15:0] dac_word,
    input logic        data_mode,
    input logic        rx_done,
    input logic [18:0] cfg_bus
);
    // R2
    out_fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out_fs |=> !ser_out_fs);

    // R8
    dac_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |=> !dac_load);

    // R8
    dac_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> data_mode);

    // R9
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_mode |=> data_mode);

    // R4
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(cfg_bus));

    // R11
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_word != $past(dac_word)) |-> dac_load);
endmodule

bind cascade_codec_port cascade_codec_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_out_fs (ser_out_fs),
    .dac_load   (dac_load),
    .dac_word   (dac_word),
    .data_mode  (data_mode),
    .rx_done    (rx_done),
    .cfg_bus    ({chain_len, mclk_div, sclk_rate, fs_rate, pwr_en})
);

// File: tb/sim_cascade_codec_port.sv
// Directed bench for cascade_codec_port: one task per scenario, each with its own checks.
module sim_cascade_codec_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_in_fs = 1'b0;
    logic        ser_out;
    logic        ser_out_fs;
    logic        sample_evt = 1'b0;
    logic [15:0] adc_word = '0;
    logic [15:0] dac_word;
    logic        dac_load;
    logic        data_mode;
    logic [2:0]  chain_len;
    logic [2:0]  mclk_div;
    logic [1:0]  sclk_rate;
    logic [2:0]  fs_rate;
    logic [7:0]  pwr_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          out_cnt = 0;
    logic [15:0] last_out = '0;
    logic [15:0] cap = '0;
    int          cap_left = 0;
    int          dac_cnt = 0;
    logic [15:0] last_dac = '0;

    always #4 clk = ~clk;

    cascade_codec_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_in_fs(ser_in_fs),
        .ser_out(ser_out), .ser_out_fs(ser_out_fs), .sample_evt(sample_evt),
        .adc_word(adc_word), .dac_word(dac_word), .dac_load(dac_load),
        .data_mode(data_mode), .chain_len(chain_len), .mclk_div(mclk_div),
        .sclk_rate(sclk_rate), .fs_rate(fs_rate), .pwr_en(pwr_en)
    );

    // Collect serial output frames and DAC strobes away from the clock edge
    always @(negedge clk) begin
        if (cap_left > 0) begin
            cap = {cap[14:0], ser_out};
            cap_left = cap_left - 1;
            if (cap_left == 0) begin
                out_cnt = out_cnt + 1;
                last_out = cap;
            end
        end else if (ser_out_fs) begin
            cap_left = 16;
        end
        if (dac_load) begin
            dac_cnt = dac_cnt + 1;
            last_dac = dac_word;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Send one frame; optionally raise sample_evt in the cycle the router acts on it
    task automatic send_word(input logic [15:0] w, input bit with_sample, input logic [15:0] adc);
        @(negedge clk);
        ser_in_fs = 1'b1;
        ser_in = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            ser_in_fs = 1'b0;
            ser_in = w[i];
        end
        @(negedge clk);
        ser_in = 1'b0;
        if (with_sample) begin
            sample_evt = 1'b1;
            adc_word = adc;
        end
        @(negedge clk);
        sample_evt = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic pulse_sample(input logic [15:0] adc);
        @(negedge clk);
        sample_evt = 1'b1;
        adc_word = adc;
        @(negedge clk);
        sample_evt = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(ser_out, 0, "R1 ser_out");
        check(ser_out_fs, 0, "R1 ser_out_fs");
        check(dac_word, 0, "R1 dac_word");
        check(dac_load, 0, "R1 dac_load");
        check(data_mode, 0, "R1 data_mode");
        check({chain_len, mclk_div, sclk_rate, fs_rate, pwr_en}, 0, "R1 cfg");
    endtask

    task automatic t_sample();
        int n = out_cnt;
        pulse_sample(16'hA5C3);
        check(ser_out_fs, 1, "R3 fs one cycle after event");
        repeat (25) @(negedge clk);
        check(out_cnt, n + 1, "R3 frame count");
        check(last_out, 16'hA5C3, "R2 R3 adc word msb first");
    endtask

    task automatic t_busy();
        int n = out_cnt;
        pulse_sample(16'h1234);
        repeat (3) @(negedge clk);
        pulse_sample(16'h5678);
        repeat (40) @(negedge clk);
        check(out_cnt, n + 1, "R10 busy request dropped");
        check(last_out, 16'h1234, "R10 first word kept");
    endtask

    task automatic t_collide();
        int n = out_cnt;
        send_word(16'h0AAA, 1'b1, 16'h6C6C);
        check(out_cnt, n + 1, "R10 collision single frame");
        check(last_out, 16'h6C6C, "R10 sample wins");
    endtask

    task automatic t_forward();
        int n = out_cnt;
        send_word(16'h7ABC, 1'b0, 16'h0);
        check(out_cnt, n + 1, "R6 plain word forwarded");
        check(last_out, 16'h7ABC, "R6 unchanged");
        send_word(16'hB25A, 1'b0, 16'h0);
        check(out_cnt, n + 2, "R5 addressed word forwarded");
        check(last_out, 16'hA25A, "R5 address decremented");
        check(mclk_div, 0, "R5 no local write");
    endtask

    task automatic t_write();
        int n = out_cnt;
        send_word(16'h82B6, 1'b0, 16'h0);
        check({mclk_div, sclk_rate, fs_rate}, {3'd6, 2'd2, 3'd5}, "R4 R7 reg B fields");
        send_word(16'h843C, 1'b0, 16'h0);
        check(pwr_en, 8'h3C, "R7 reg C");
        send_word(16'h8AFF, 1'b0, 16'h0);
        check({chain_len, mclk_div, sclk_rate, fs_rate, pwr_en, data_mode},
              {3'd0, 3'd6, 2'd2, 3'd5, 8'h3C, 1'b0}, "R4 bad select ignored");
        check(out_cnt, n, "R4 local words consumed");
    endtask

    task automatic t_data();
        int n;
        int d;
        send_word(16'h8005, 1'b0, 16'h0);
        check({data_mode, chain_len}, {1'b1, 3'd2}, "R7 reg A mode and length");
        n = out_cnt;
        d = dac_cnt;
        send_word(16'h1111, 1'b0, 16'h0);
        check(out_cnt, n + 1, "R8 below threshold forwarded");
        check(last_out, 16'h1111, "R8 forwarded word");
        check(dac_cnt, d, "R8 no load below threshold");
        send_word(16'h2222, 1'b0, 16'h0);
        check(dac_cnt, d + 1, "R8 load at threshold");
        check(last_dac, 16'h2222, "R8 dac word");
        check(out_cnt, n + 1, "R8 threshold word not forwarded");
        send_word(16'h3333, 1'b0, 16'h0);
        check(last_out, 16'h3333, "R8 counter restarted");
        send_word(16'h4444, 1'b0, 16'h0);
        check(last_dac, 16'h4444, "R8 second load");
        send_word(16'h8003, 1'b0, 16'h0);
        check(chain_len, 3'd2, "R9 control word not decoded");
        check(last_out, 16'h8003, "R9 forwarded as data");
        send_word(16'h8000, 1'b0, 16'h0);
        check(data_mode, 1, "R9 stays in data mode");
        check(last_dac, 16'h8000, "R9 flagged word loaded as data");
        pulse_sample(16'h0F00);
        repeat (25) @(negedge clk);
        check(dac_word, 16'h8000, "R11 dac word held");
    endtask

    task automatic t_len_zero();
        int d;
        do_reset();
        send_word(16'h8001, 1'b0, 16'h0);
        d = dac_cnt;
        send_word(16'h0F0F, 1'b0, 16'h0);
        check(dac_cnt, d + 1, "R8 zero length acts as one");
        check(last_dac, 16'h0F0F, "R8 zero length word");
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sample();
        t_busy();
        t_collide();
        t_forward();
        t_write();
        t_data();
        t_len_zero();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule